// File: doc/BRIEF.md
# Delay Tap Sweep and Centering Engine

This engine finds the best delay tap for one capture path: a single read data bit, or the echo clock that strobes it, for one chosen capture edge. After a start pulse it sets the delay to tap zero. At every tap it runs a full round: it writes eight fixed scrambled bytes to the memory, reads them back, and compares each byte. A tap passes only when all eight bytes of its round match.

The engine moves the delay up one tap at a time. It remembers the first passing tap and the last passing tap. When the first failure after that window appears, or when the top tap has been tried, it loads the midpoint of the window. Then it pulses done and reports pass. If the delay line runs out of taps, the out-of-range flag is raised. When no tap passed at all, no center value is loaded and pass stays low.

Memory commands and the delay element itself sit outside this block. The engine only raises write and read requests, one byte per acknowledge, and drives increment and load controls for the tap.

Top module: `tap_sweep_center`

## Requirements
- R1: While reset is held, and at release, `done_o`, `pass_o`, `oor_o`, `wr_req_o`, `rd_req_o`, `tap_inc_o`, `tap_load_o` and `cap_edge_o` are 0.
- R2: A `start_i` pulse while idle latches `edge_sel_i` onto `cap_edge_o` (0 selects the falling capture edge, 1 the rising edge). During a run, changes on `edge_sel_i` and further `start_i` pulses have no effect on `cap_edge_o` or on the result.
- R3: The first action of a run is a one-cycle `tap_load_o` pulse with `tap_val_o` = 0.
- R4: Each round writes exactly eight bytes on `wr_data_o`, one per `wr_req_o`/`wr_ack_i` handshake, in the order 0x96, 0x2D, 0x5A, 0xB4, 0x69, 0xD2, 0xA5, 0x4B.
- R5: After its writes, each round reads exactly eight bytes, one per `rd_req_o`/`rd_ack_i` handshake, taking `rd_data_i` in the cycle of the acknowledge. It completes all eight reads even when an earlier byte already mismatched.
- R6: A tap passes only if every one of the eight read bytes equals the byte written at the same position. A single wrong byte at any position fails the tap.
- R7: A round that does not end the sweep is followed by a one-cycle `tap_inc_o` pulse and a new round at the next tap. Increment and load never pulse together.
- R8: The window runs from the first passing tap to the last passing tap before the next failing tap. The first failing round after a window ends the sweep, so the number of increments equals the tap of that failing round.
- R9: When a window exists, the engine pulses `tap_load_o` for one cycle with `tap_val_o` = (first + last) >> 1. In the next cycle it pulses `done_o` with `pass_o` = 1.
- R10: Finishing the round at tap 63 without a closed window raises `oor_o`. If taps were passing at that point, the window ends at 63 and is centered as in R9. If no tap passed, no load follows, and `done_o` pulses with `pass_o` = 0.
- R11: `done_o` is high for exactly one cycle per run. `pass_o` and `oor_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a sweep (taken only when idle) |
| edge_sel_i | input | 1 | Capture edge for this run: 0 falling, 1 rising |
| wr_req_o | output | 1 | Request to write one test byte |
| wr_data_o | output | 8 | Test byte to write |
| wr_ack_i | input | 1 | Write accepted; engine advances to the next byte |
| rd_req_o | output | 1 | Request to read one byte back |
| rd_ack_i | input | 1 | Read data valid on `rd_data_i` |
| rd_data_i | input | 8 | Captured read-back byte |
| cap_edge_o | output | 1 | Latched capture edge select for the capture path |
| tap_inc_o | output | 1 | Step the delay one tap up |
| tap_load_o | output | 1 | Load `tap_val_o` into the delay element |
| tap_val_o | output | 6 | Tap value for a load |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | A window was found and centered |
| oor_o | output | 1 | Sweep reached the end of the delay line |

## Verification
Two decisions can land on the same round: the end of the delay line, and the final passing tap of a window. This happens when taps near 63, or tap 63 alone, pass. The bench places the memory model's good window there and expects `oor_o` and `pass_o` both set, with the midpoint loaded one cycle before done. A second overlap also gets its own vectors. Here the last byte of a round is the only corrupted one, so its mismatch falls in the same acknowledge as the round's final read. Those vectors check that this single late error still fails the tap.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ZERO   = 3'd1,
    ST_WRITE  = 3'd2,
    ST_READ   = 3'd3,
    ST_JUDGE  = 3'd4,
    ST_STEP   = 3'd5,
    ST_CENTER = 3'd6,
    ST_FIN    = 3'd7
  } tsc_state_e;

endpackage

// File: rtl/tsc_rst_sync.sv
module tsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tsc_pattern_chk.sv
module tsc_pattern_chk #(
  parameter int              DATA_W = 8,
  parameter int              NPAT   = 8,
  parameter logic [DATA_W-1:0] SEED = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              round_clr,
  input  logic              adv,
  input  logic              cmp_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] exp_o,
  output logic              last_o,
  output logic              all_ok_o
);
  localparam int IDX_W = (NPAT > 1) ? $clog2(NPAT) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NPAT - 1);

  // Each pattern is the seed rotated left by its position.
  logic [DATA_W-1:0] pat_tbl [NPAT];

  genvar g;
  generate
    for (g = 0; g < NPAT; g++) begin : g_pat
      localparam int ROT = g % DATA_W;
      if (ROT == 0) begin : g_plain
        assign pat_tbl[g] = SEED;
      end else begin : g_rot
        assign pat_tbl[g] = {SEED[DATA_W-1-ROT:0], SEED[DATA_W-1:DATA_W-ROT]};
      end
    end
  endgenerate

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ok_q, ok_d;
  logic             mism;

  assign exp_o  = pat_tbl[idx_q];
  assign last_o = (idx_q == IDX_LAST);
  assign mism   = cmp_en && (rd_data != exp_o);

  always_comb begin
    idx_d = idx_q;
    ok_d  = ok_q;
    if (round_clr) begin
      idx_d = '0;
      ok_d  = 1'b1;
    end else begin
      if (adv) idx_d = last_o ? '0 : idx_q + IDX_W'(1);
      if (mism) ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      idx_q <= idx_d;
      ok_q  <= ok_d;
    end
  end

  assign all_ok_o = ok_q;

  // R6
  mism_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && (rd_data != exp_o)) |=> !all_ok_o);

endmodule

// File: rtl/tsc_window_trk.sv
module tsc_window_trk #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_zero,
  input  logic             tap_step,
  input  logic             judge,
  input  logic             tap_ok,
  output logic [TAP_W-1:0] tap_o,
  output logic             found_o,
  output logic             at_max_o,
  output logic [TAP_W-1:0] center_o
);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  logic [TAP_W-1:0] tap_q, tap_d;
  logic [TAP_W-1:0] first_q, first_d;
  logic [TAP_W-1:0] last_q, last_d;
  logic             found_q, found_d;
  logic [TAP_W:0]   span_sum;

  always_comb begin
    tap_d   = tap_q;
    first_d = first_q;
    last_d  = last_q;
    found_d = found_q;
    if (tap_zero) begin
      tap_d   = '0;
      found_d = 1'b0;
    end else begin
      if (tap_step) tap_d = tap_q + TAP_W'(1);
      if (judge && tap_ok) begin
        if (!found_q) first_d = tap_q;
        last_d  = tap_q;
        found_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
      found_q <= 1'b0;
    end else begin
      tap_q   <= tap_d;
      first_q <= first_d;
      last_q  <= last_d;
      found_q <= found_d;
    end
  end

  assign span_sum = {1'b0, first_q} + {1'b0, last_q};
  assign center_o = span_sum[TAP_W:1];
  assign tap_o    = tap_q;
  assign found_o  = found_q;
  assign at_max_o = (tap_q == TAP_MAX);

  // R10
  no_step_past_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_step |-> !at_max_o);

  // R8
  window_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> (first_q <= last_q));

endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             edge_sel,
  input  logic             wr_ack,
  input  logic             rd_ack,
  input  logic             pat_last,
  input  logic             all_ok,
  input  logic             found,
  input  logic             at_max,
  input  logic [TAP_W-1:0] center,
  output logic             wr_req,
  output logic             rd_req,
  output logic             pat_adv,
  output logic             cmp_en,
  output logic             round_clr,
  output logic             tap_zero,
  output logic             tap_step,
  output logic             judge,
  output logic             tap_inc,
  output logic             tap_load,
  output logic [TAP_W-1:0] tap_val,
  output logic             cap_edge,
  output logic             done,
  output logic             pass,
  output logic             oor
);
  tsc_state_e state_q, state_d;
  logic       edge_q, edge_d;
  logic       pass_q, pass_d;
  logic       oor_q, oor_d;
  logic       busy;

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    pass_d  = pass_q;
    oor_d   = oor_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_ZERO;
        edge_d  = edge_sel;
        pass_d  = 1'b0;
        oor_d   = 1'b0;
      end
      ST_ZERO:  state_d = ST_WRITE;
      ST_WRITE: if (wr_ack && pat_last) state_d = ST_READ;
      ST_READ:  if (rd_ack && pat_last) state_d = ST_JUDGE;
      ST_JUDGE: begin
        if (!all_ok && found) begin
          state_d = ST_CENTER;
        end else if (at_max) begin
          oor_d   = 1'b1;
          state_d = (found || all_ok) ? ST_CENTER : ST_FIN;
        end else begin
          state_d = ST_STEP;
        end
      end
      ST_STEP:  state_d = ST_WRITE;
      ST_CENTER: begin
        pass_d  = 1'b1;
        state_d = ST_FIN;
      end
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= 1'b0;
      pass_q  <= 1'b0;
      oor_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      pass_q  <= pass_d;
      oor_q   <= oor_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign wr_req    = (state_q == ST_WRITE);
  assign rd_req    = (state_q == ST_READ);
  assign pat_adv   = (wr_req && wr_ack) || (rd_req && rd_ack);
  assign cmp_en    = rd_req && rd_ack;
  assign round_clr = (state_q == ST_ZERO) || (state_q == ST_STEP);
  assign tap_zero  = (state_q == ST_ZERO);
  assign tap_step  = (state_q == ST_STEP);
  assign judge     = (state_q == ST_JUDGE);
  assign tap_inc   = tap_step;
  assign tap_load  = (state_q == ST_ZERO) || (state_q == ST_CENTER);
  assign tap_val   = (state_q == ST_CENTER) ? center : '0;
  assign done      = (state_q == ST_FIN);
  assign cap_edge  = edge_q;
  assign pass      = pass_q;
  assign oor       = oor_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  center_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> $past(tap_load));

  // R2
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cap_edge));

  // R10
  oor_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oor) |-> $past(at_max));

endmodule

// File: rtl/tap_sweep_center.sv
module tap_sweep_center #(
  parameter int                TAP_W  = 6,
  parameter int                DATA_W = 8,
  parameter int                NPAT   = 8,
  parameter logic [DATA_W-1:0] SEED   = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              edge_sel_i,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cap_edge_o,
  output logic              tap_inc_o,
  output logic              tap_load_o,
  output logic [TAP_W-1:0]  tap_val_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              oor_o
);
  logic             rst_n_s;
  logic             pat_adv, cmp_en, round_clr, pat_last, all_ok;
  logic             tap_zero, tap_step, judge;
  logic             found, at_max;
  logic [TAP_W-1:0] center, tap_cur;

  tsc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  tsc_pattern_chk #(
    .DATA_W (DATA_W),
    .NPAT   (NPAT),
    .SEED   (SEED)
  ) u_pat (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .round_clr (round_clr),
    .adv       (pat_adv),
    .cmp_en    (cmp_en),
    .rd_data   (rd_data_i),
    .exp_o     (wr_data_o),
    .last_o    (pat_last),
    .all_ok_o  (all_ok)
  );

  tsc_window_trk #(
    .TAP_W (TAP_W)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tap_zero (tap_zero),
    .tap_step (tap_step),
    .judge    (judge),
    .tap_ok   (all_ok),
    .tap_o    (tap_cur),
    .found_o  (found),
    .at_max_o (at_max),
    .center_o (center)
  );

  tsc_ctrl #(
    .TAP_W (TAP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start_i),
    .edge_sel  (edge_sel_i),
    .wr_ack    (wr_ack_i),
    .rd_ack    (rd_ack_i),
    .pat_last  (pat_last),
    .all_ok    (all_ok),
    .found     (found),
    .at_max    (at_max),
    .center    (center),
    .wr_req    (wr_req_o),
    .rd_req    (rd_req_o),
    .pat_adv   (pat_adv),
    .cmp_en    (cmp_en),
    .round_clr (round_clr),
    .tap_zero  (tap_zero),
    .tap_step  (tap_step),
    .judge     (judge),
    .tap_inc   (tap_inc_o),
    .tap_load  (tap_load_o),
    .tap_val   (tap_val_o),
    .cap_edge  (cap_edge_o),
    .done      (done_o),
    .pass      (pass_o),
    .oor       (oor_o)
  );

  // R8
  center_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tap_load_o && !tap_zero) |-> (tap_val_o <= tap_cur));

endmodule

// File: tb/tap_sweep_center_bench.sv
module tap_sweep_center_bench;
  typedef struct packed {
    logic       cedge;
    logic       v1;
    logic [5:0] lo1;
    logic [5:0] hi1;
    logic       v2;
    logic [5:0] lo2;
    logic [5:0] hi2;
    logic [2:0] bad;
    logic       e_pass;
    logic [5:0] e_ctr;
    logic       e_oor;
    logic [6:0] e_incs;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 6'd10, 6'd20, 1'b0, 6'd0,  6'd0,  3'd0, 1'b1, 6'd15, 1'b0, 7'd21},
    '{1'b1, 1'b1, 6'd0,  6'd5,  1'b0, 6'd0,  6'd0,  3'd3, 1'b1, 6'd2,  1'b0, 7'd6},
    '{1'b0, 1'b1, 6'd60, 6'd63, 1'b0, 6'd0,  6'd0,  3'd7, 1'b1, 6'd61, 1'b1, 7'd63},
    '{1'b1, 1'b0, 6'd0,  6'd0,  1'b0, 6'd0,  6'd0,  3'd5, 1'b0, 6'd0,  1'b1, 7'd63},
    '{1'b0, 1'b1, 6'd63, 6'd63, 1'b0, 6'd0,  6'd0,  3'd2, 1'b1, 6'd63, 1'b1, 7'd63},
    '{1'b1, 1'b1, 6'd30, 6'd33, 1'b0, 6'd0,  6'd0,  3'd7, 1'b1, 6'd31, 1'b0, 7'd34},
    '{1'b0, 1'b1, 6'd5,  6'd8,  1'b1, 6'd20, 6'd25, 3'd4, 1'b1, 6'd6,  1'b0, 7'd9},
    '{1'b1, 1'b1, 6'd0,  6'd0,  1'b0, 6'd0,  6'd0,  3'd0, 1'b1, 6'd0,  1'b0, 7'd1}
  };

  localparam logic [7:0] PAT [8] = '{8'h96, 8'h2D, 8'h5A, 8'hB4, 8'h69, 8'hD2, 8'hA5, 8'h4B};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, edge_sel_i;
  logic       wr_req_o, wr_ack_i, rd_req_o, rd_ack_i;
  logic [7:0] wr_data_o, rd_data_i;
  logic       cap_edge_o, tap_inc_o, tap_load_o, done_o, pass_o, oor_o;
  logic [5:0] tap_val_o;

  always #4 clk = ~clk;

  tap_sweep_center u_tap_sweep_center (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .edge_sel_i(edge_sel_i),
    .wr_req_o(wr_req_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .cap_edge_o(cap_edge_o), .tap_inc_o(tap_inc_o), .tap_load_o(tap_load_o),
    .tap_val_o(tap_val_o), .done_o(done_o), .pass_o(pass_o), .oor_o(oor_o)
  );

  int n_chk = 0, n_bad = 0;
  vec_t cur;
  int  m_tap, wr_cnt, rd_cnt, inc_cnt, load_cnt, first_load, last_load;
  int  last_load_cyc, done_cyc, cyc, wr_bad, round_bad, done_wide;
  bit  done_seen, done_prev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_win(input int t);
    return (cur.v1 && t >= int'(cur.lo1) && t <= int'(cur.hi1)) ||
           (cur.v2 && t >= int'(cur.lo2) && t <= int'(cur.hi2));
  endfunction

  task automatic clear_log();
    m_tap = 0; wr_cnt = 0; rd_cnt = 0; inc_cnt = 0; load_cnt = 0;
    first_load = -1; last_load = -1; last_load_cyc = -10; done_cyc = -1;
    wr_bad = 0; round_bad = 0; done_wide = 0; done_seen = 0;
  endtask

  // Memory and delay-line model, acting on falling clock edges.
  initial begin
    wr_ack_i = 1'b0; rd_ack_i = 1'b0; rd_data_i = 8'h00; cyc = 0; done_prev = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        wr_ack_i = 1'b0; rd_ack_i = 1'b0; done_prev = 1'b0;
      end else begin
        if (tap_inc_o) begin
          if (wr_cnt != 8 || rd_cnt != 8) round_bad++;
          m_tap++; inc_cnt++; wr_cnt = 0; rd_cnt = 0;
        end
        if (tap_load_o) begin
          m_tap = int'(tap_val_o); load_cnt++;
          if (load_cnt == 1) first_load = int'(tap_val_o);
          last_load = int'(tap_val_o); last_load_cyc = cyc;
          wr_cnt = 0; rd_cnt = 0;
        end
        if (done_o) begin
          if (done_prev) done_wide++;
          done_seen = 1'b1; done_cyc = cyc;
        end
        done_prev = done_o;
        if (wr_ack_i) wr_ack_i = 1'b0;
        else if (wr_req_o) begin
          if (wr_cnt > 7 || wr_data_o != PAT[wr_cnt[2:0]]) wr_bad++;
          wr_cnt++; wr_ack_i = 1'b1;
        end
        if (rd_ack_i) rd_ack_i = 1'b0;
        else if (rd_req_o) begin
          rd_data_i = PAT[rd_cnt[2:0]];
          if (!in_win(m_tap) && rd_cnt[2:0] == cur.bad) rd_data_i = rd_data_i ^ 8'h10;
          rd_cnt++; rd_ack_i = 1'b1;
        end
      end
    end
  end

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    summary_and_end();
  end

  task automatic pulse_start();
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit disturb);
    int t;
    cur = v;
    clear_log();
    edge_sel_i = v.cedge;
    pulse_start();
    t = 0;
    while (!done_seen && t < 20000) begin
      @(posedge clk); #2; t++;
      if (disturb && t == 150) begin
        edge_sel_i = ~v.cedge;
        pulse_start();
      end
    end
    chk(done_seen, "R11 done reached", int'(done_seen), 1);
    chk(pass_o == v.e_pass, "R9 R10 pass flag", int'(pass_o), int'(v.e_pass));
    chk(oor_o == v.e_oor, "R10 out-of-range flag", int'(oor_o), int'(v.e_oor));
    chk(first_load == 0, "R3 initial tap load", first_load, 0);
    chk(wr_bad == 0, "R4 write order", wr_bad, 0);
    chk(round_bad == 0, "R5 R7 full round before step", round_bad, 0);
    chk(inc_cnt == int'(v.e_incs), "R8 R6 increments before stop", inc_cnt, int'(v.e_incs));
    chk(cap_edge_o == v.cedge, "R2 capture edge latched", int'(cap_edge_o), int'(v.cedge));
    if (v.e_pass) begin
      chk(last_load == int'(v.e_ctr), "R9 center value", last_load, int'(v.e_ctr));
      chk(done_cyc - last_load_cyc == 1, "R9 done after load", done_cyc - last_load_cyc, 1);
    end else begin
      chk(load_cnt == 1, "R10 no center load", load_cnt, 1);
    end
    repeat (10) @(posedge clk); #2;
    chk(done_wide == 0 && !done_o, "R11 done single cycle", done_wide, 0);
    chk(pass_o == v.e_pass && oor_o == v.e_oor, "R11 flags held",
        int'({pass_o, oor_o}), int'({v.e_pass, v.e_oor}));
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; edge_sel_i = 1'b0;
    cur = VEC[0];
    clear_log();
    repeat (4) @(posedge clk); #2;
    chk({done_o, pass_o, oor_o, wr_req_o, rd_req_o, tap_inc_o, tap_load_o, cap_edge_o} == 8'h00,
        "R1 reset outputs",
        int'({done_o, pass_o, oor_o, wr_req_o, rd_req_o, tap_inc_o, tap_load_o, cap_edge_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #2;
    chk({done_o, wr_req_o, rd_req_o, tap_load_o} == 4'h0, "R1 after release",
        int'({done_o, wr_req_o, rd_req_o, tap_load_o}), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // R2: edge change and extra start in the middle of a run are ignored
    run_vec(VEC[0], 1'b1);
    run_vec(VEC[1], 1'b1);

    // R1: reset in the middle of a sweep returns the block to idle
    cur = VEC[3];
    clear_log();
    edge_sel_i = 1'b1;
    pulse_start();
    repeat (300) @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    chk({done_o, pass_o, oor_o, wr_req_o, rd_req_o, tap_inc_o, tap_load_o, cap_edge_o} == 8'h00,
        "R1 mid-run reset",
        int'({done_o, pass_o, oor_o, wr_req_o, rd_req_o, tap_inc_o, tap_load_o, cap_edge_o}), 0);
    repeat (3) @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #2;
    run_vec(VEC[5], 1'b0);

    summary_and_end();
  end
endmodule